// File: doc/BRIEF.md
# Print-Head Row Address Scanner

This block produces the row-select lines for a pair of 13-row ink-jet print heads. A small position counter walks a fixed 14-entry sequence of 4-bit codes. Entry zero is the idle code. The other entries are Gray-like codes for rows 1 to 13, and adjacent entries differ in one bit. A 4-to-13 decoder turns the active code into a one-hot row vector. A steering stage then routes that vector to exactly one of the two heads, or to neither.

Two sources can drive the decoder. In counter mode, three of the four select pins change role: they become a count clock, an active-low count clear and a direction flag. Each rising edge of the count clock, seen on the system clock, moves the scan one row up or down. In direct mode, all four select pins feed the decoder as a raw code, so an outside scheduler can run any row order it likes. The counter keeps its position while direct mode is active.

Top module: `rowscan_top`

## Requirements
- R1: With ctr_mode low, sel_in feeds the decoder directly with no clock delay. Codes 0001, 0011, 0010, 0110, 0111, 0101 and 0100 select rows 1 to 7 in that order. Row n is bit n-1 of the row vector.
- R2: With ctr_mode low, codes 1100, 1101, 1111, 1110, 1010 and 1000 select rows 8 to 13 in that order.
- R3: Codes 0000, 1001 and 1011 drive no row on either head.
- R4: With ctr_mode high, sel_in[0] is the count clock. The counter moves one step at the clk edge where sel_in[0] is sampled high, if it was sampled low at the edge before. The decoded counter code appears on the rows right after that edge.
- R5: With sel_in[2] high, the counter steps up through the row order of R1 and R2. After row 13 (1000) it wraps to idle (0000).
- R6: With sel_in[2] low, the counter steps down through the same order. From idle (0000) it wraps to row 13 (1000).
- R7: With ctr_mode high and sel_in[1] low, the counter clears to idle at the next clk edge. The clear wins over a simultaneous count-clock edge.
- R8: While ctr_mode is low, the counter ignores count-clock edges and keeps its position. On return to counter mode, that position drives the rows again.
- R9: head_b low routes the decoded row to row_a, and head_b high routes it to row_b. The other head's rows stay all zero.
- R10: While head_en_n is high, all 26 row outputs are zero, whatever the code.
- R11: While rst_n is low, the counter is held at idle and the count-clock edge history is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctr_mode | input | 1 | 1 = internal counter drives the decoder, 0 = direct select |
| sel_in | input | 4 | Direct code; in counter mode bit0 = count clock, bit1 = clear_n, bit2 = up |
| head_b | input | 1 | 0 = head A, 1 = head B |
| head_en_n | input | 1 | Active-low head enable |
| row_a | output | 13 | One-hot row selects, head A |
| row_b | output | 13 | One-hot row selects, head B |

## Verification
The bench builds the block with its default parameters: a 4-bit code, 13 rows, a 14-entry sequence and no extra synchronizer stages on the count clock. With zero synchronizer stages, a count-clock edge shows up on the rows at the very clk edge that samples it, so the reference model can predict every output cycle by cycle. These settings let the bench reach both wrap points and every decoder code, including the three idle ones. They also expose the clear-versus-step priority, and the position the counter holds across a visit to direct mode.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

   localparam int unsigned SEQ_LEN = 14;

   // Code held at each scan position; position 0 is idle.
   function automatic logic [3:0] seq_code(input logic [3:0] pos);
      logic [3:0] c;
      case (pos)
         4'd1:    c = 4'b0001;
         4'd2:    c = 4'b0011;
         4'd3:    c = 4'b0010;
         4'd4:    c = 4'b0110;
         4'd5:    c = 4'b0111;
         4'd6:    c = 4'b0101;
         4'd7:    c = 4'b0100;
         4'd8:    c = 4'b1100;
         4'd9:    c = 4'b1101;
         4'd10:   c = 4'b1111;
         4'd11:   c = 4'b1110;
         4'd12:   c = 4'b1010;
         4'd13:   c = 4'b1000;
         default: c = 4'b0000;
      endcase
      return c;
   endfunction

   // Row number selected by a code; 0 means no row.
   function automatic logic [3:0] code_row(input logic [3:0] code);
      logic [3:0] r;
      r = '0;
      for (int i = 1; i < 14; i++) begin
         if (seq_code(4'(i)) == code) r = 4'(i);
      end
      return r;
   endfunction

endpackage

// File: rtl/rowscan_counter.sv
module rowscan_counter #(
   parameter int unsigned SEQ_LEN     = 14,
   parameter int unsigned POS_W       = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step_clk,
   input  logic             clr_n,
   input  logic             up,
   output logic [POS_W-1:0] pos_q
);

   localparam logic [POS_W-1:0] LAST = POS_W'(SEQ_LEN - 1);

   if ((1 << POS_W) < SEQ_LEN) begin : g_bad_width
      $error("rowscan_counter: POS_W too small for SEQ_LEN");
   end

   logic chain [0:SYNC_STAGES];
   assign chain[0] = step_clk;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i+1] <= 1'b0;
         else        chain[i+1] <= chain[i];
      end
   end

   logic clk_s, prev_q, rise;
   assign clk_s = chain[SYNC_STAGES];
   assign rise  = clk_s & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= clk_s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (run) begin
         if (!clr_n)
            pos_q <= '0;
         else if (rise) begin
            if (up) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
            else    pos_q <= (pos_q == '0) ? LAST : pos_q - 1'b1;
         end
      end
   end

   p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && clr_n && rise && up) |=>
      (pos_q == (($past(pos_q) == LAST) ? '0 : POS_W'($past(pos_q) + 1'b1))));

   p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && clr_n && rise && !up) |=>
      (pos_q == (($past(pos_q) == '0) ? LAST : POS_W'($past(pos_q) - 1'b1))));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr_n) |=> (pos_q == '0));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> $stable(pos_q));

   p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q <= LAST));

endmodule

// File: rtl/rowscan_decode.sv
module rowscan_decode
   import rowscan_pkg::*;
#(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned ROWS   = 13
) (
   input  logic [CODE_W-1:0] code,
   output logic [ROWS-1:0]   rows
);

   logic [CODE_W-1:0] row_no;
   assign row_no = code_row(code);

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      assign rows[i] = (row_no == CODE_W'(i + 1));
   end

   always_comb begin
      if (!$isunknown(code)) begin
         p_row_onehot_r1: assert ($onehot0(rows));
         p_idle_codes_r3: assert (!((code == 4'b0000 || code == 4'b1001 ||
                                     code == 4'b1011) && (|rows)));
      end
   end

endmodule

// File: rtl/rowscan_steer.sv
module rowscan_steer #(
   parameter int unsigned ROWS = 13
) (
   input  logic [ROWS-1:0] rows,
   input  logic            head_b,
   input  logic            en_n,
   output logic [ROWS-1:0] row_a,
   output logic [ROWS-1:0] row_b
);

   always_comb begin
      row_a = '0;
      row_b = '0;
      if (!en_n) begin
         if (head_b) row_b = rows;
         else        row_a = rows;
      end
   end

   always_comb begin
      if (!$isunknown({rows, head_b, en_n})) begin
         p_one_head_r9: assert (!((|row_a) && (|row_b)));
         p_gate_off_r10: assert (!en_n || ((row_a == '0) && (row_b == '0)));
      end
   end

endmodule

// File: rtl/rowscan_top.sv
module rowscan_top #(
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned ROWS        = 13,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctr_mode,
   input  logic [CODE_W-1:0] sel_in,
   input  logic              head_b,
   input  logic              head_en_n,
   output logic [ROWS-1:0]   row_a,
   output logic [ROWS-1:0]   row_b
);
   import rowscan_pkg::*;

   localparam int unsigned POS_W = CODE_W;

   if (CODE_W != 4 || ROWS != 13) begin : g_bad_cfg
      $error("rowscan_top: code table fixed at 4-bit codes and 13 rows");
   end

   logic [POS_W-1:0]  pos;
   logic [CODE_W-1:0] cnt_code, dec_code;
   logic [ROWS-1:0]   rows;

   rowscan_counter #(
      .SEQ_LEN    (SEQ_LEN),
      .POS_W      (POS_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctr_mode),
      .step_clk(sel_in[0]),
      .clr_n   (sel_in[1]),
      .up      (sel_in[2]),
      .pos_q   (pos)
   );

   assign cnt_code = seq_code(pos);
   assign dec_code = ctr_mode ? cnt_code : sel_in;

   rowscan_decode #(.CODE_W(CODE_W), .ROWS(ROWS)) u_dec (
      .code(dec_code),
      .rows(rows)
   );

   rowscan_steer #(.ROWS(ROWS)) u_steer (
      .rows  (rows),
      .head_b(head_b),
      .en_n  (head_en_n),
      .row_a (row_a),
      .row_b (row_b)
   );

   p_reset_idle_r11: assert property (@(posedge clk)
      (!rst_n) |=> (cnt_code == '0));

endmodule

// File: tb/sim_rowscan_top.sv
`timescale 1ns/1ps
module sim_rowscan_top;
   localparam int PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        ctr_mode = 1;
   logic [3:0]  sel_in = 4'b0110;
   logic        head_b = 0;
   logic        head_en_n = 0;
   logic [12:0] row_a, row_b;

   int n_run = 0, n_fail = 0, cyc = 0;
   string cur_req = "R11";
   bit started = 0;

   always #(PERIOD/2) clk = ~clk;

   rowscan_top u0 (.clk(clk), .rst_n(rst_n), .ctr_mode(ctr_mode), .sel_in(sel_in),
                   .head_b(head_b), .head_en_n(head_en_n), .row_a(row_a), .row_b(row_b));

   // scan order taken from R1/R2, index 0 idle
   logic [3:0] order [14] = '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0110, 4'b0111,
                              4'b0101, 4'b0100, 4'b1100, 4'b1101, 4'b1111, 4'b1110,
                              4'b1010, 4'b1000};

   int m_pos = 0;
   bit m_prev = 0;

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         m_pos  <= 0;
         m_prev <= 0;
      end else begin
         if (ctr_mode) begin
            if (!sel_in[1]) m_pos <= 0;
            else if (sel_in[0] && !m_prev)
               m_pos <= sel_in[2] ? (m_pos + 1) % 14 : (m_pos + 13) % 14;
         end
         m_prev <= sel_in[0];
      end
   end

   always @(negedge clk) begin
      if (started) begin
         logic [3:0]  code;
         int          row;
         logic [12:0] ea, eb, r;
         code = ctr_mode ? order[m_pos] : sel_in;
         row = 0;
         for (int i = 1; i < 14; i++) if (order[i] == code) row = i;
         r = '0;
         if (row != 0) r[row-1] = 1'b1;
         ea = (!head_en_n && !head_b) ? r : '0;
         eb = (!head_en_n && head_b) ? r : '0;
         n_run++;
         if (row_a !== ea || row_b !== eb) begin
            n_fail++;
            $display("FAIL %s: row_a=%b row_b=%b expected row_a=%b row_b=%b",
                     cur_req, row_a, row_b, ea, eb);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected <= 20000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic drive(input bit im, input logic [3:0] s, input bit hb, input bit en);
      @(posedge clk);
      #(PERIOD/4);
      ctr_mode = im; sel_in = s; head_b = hb; head_en_n = en;
   endtask

   // one count-clock pulse in counter mode; bit2 = direction
   task automatic pulse(input bit up_dir);
      drive(1, {1'b0, up_dir, 1'b1, 1'b1}, head_b, head_en_n);
      drive(1, {1'b0, up_dir, 1'b1, 1'b0}, head_b, head_en_n);
   endtask

   initial begin
      // R11: reset state
      cur_req = "R11";
      repeat (3) @(posedge clk);
      #(PERIOD/4) rst_n = 1;
      // R1 R2 R3 R9: every code in direct mode on both heads
      for (int h = 0; h < 2; h++) begin
         for (int c = 0; c < 16; c++) begin
            cur_req = (c == 0 || c == 9 || c == 11) ? "R3" :
                      (c >= 8) ? "R2" : "R1";
            if (h == 1) cur_req = "R9";
            drive(0, 4'(c), h[0], 0);
         end
      end
      // R10: disabled heads
      cur_req = "R10";
      for (int c = 0; c < 16; c++) drive(0, 4'(c), c[0], 1);
      // R4 R5: count up through the wrap
      cur_req = "R5";
      drive(1, 4'b0110, 0, 0);
      for (int k = 0; k < 16; k++) pulse(1);
      // R4: level high held does not re-step
      cur_req = "R4";
      drive(1, 4'b0111, 1, 0);
      repeat (4) drive(1, 4'b0111, 1, 0);
      drive(1, 4'b0110, 1, 0);
      // R6: count down through the wrap
      cur_req = "R6";
      for (int k = 0; k < 17; k++) pulse(0);
      // R7: clear beats a simultaneous edge
      cur_req = "R7";
      pulse(1); pulse(1);
      drive(1, 4'b0101, 0, 0);
      drive(1, 4'b0100, 0, 0);
      drive(1, 4'b0110, 0, 0);
      pulse(1);
      // R8: direct mode leaves position intact
      cur_req = "R8";
      pulse(1); pulse(1);
      for (int k = 0; k < 4; k++) begin
         drive(0, 4'b0001, 0, 0);
         drive(0, 4'b0000, 0, 0);
      end
      drive(0, 4'b0100, 0, 0);
      drive(1, 4'b0110, 0, 0);
      drive(1, 4'b0110, 0, 0);
      pulse(1);
      // R11: reset mid scan
      cur_req = "R11";
      pulse(1);
      @(posedge clk); #(PERIOD/4) rst_n = 0;
      repeat (2) drive(1, 4'b0111, 0, 0);
      @(posedge clk); #(PERIOD/4) rst_n = 1;
      drive(1, 4'b0110, 0, 0);
      pulse(1);
      repeat (2) @(posedge clk);
      @(negedge clk); #1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule